// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle Core

This block turns the six-bit primary opcode of a single-cycle processor into every control point the datapath needs in that same cycle. The controls are the write-register select, the ALU second-operand select, the writeback source select, the register-file and memory write enables, the branch and jump flags, the immediate extender mode, and a three-bit class code for the separate ALU function decoder. The decoder has no clock and no state. The outputs follow the opcode combinationally.

Each supported opcode is matched as a full six-bit product term, which gives a one-hot row select. An OR-plane then gathers each control output from the rows that set it. Any opcode outside the supported set matches no row, so every output is 0 and nothing is written. A control that an instruction does not use is also driven to 0, so the output word is always fully defined.

Top module: `sc_main_ctrl`

## Requirements
- R1: Opcode 000000 (register-register class) gives reg_dst=1, alu_b_imm=0, mem_to_reg=0, reg_we=1, mem_we=0, branch=0, jump=0, ext_sign=0, alu_op=100.
- R2: Opcode 001101 (or-immediate) gives reg_dst=0, alu_b_imm=1, mem_to_reg=0, reg_we=1, mem_we=0, branch=0, jump=0, ext_sign=0 (zero extend), alu_op=010.
- R3: Opcode 100011 (load word) gives reg_dst=0, alu_b_imm=1, mem_to_reg=1, reg_we=1, mem_we=0, branch=0, jump=0, ext_sign=1 (sign extend), alu_op=000.
- R4: Opcode 101011 (store word) gives alu_b_imm=1, mem_we=1, reg_we=0, ext_sign=1, alu_op=000, with reg_dst, mem_to_reg, branch and jump all 0.
- R5: Opcode 000100 (branch if equal) gives branch=1, alu_b_imm=0, reg_we=0, mem_we=0, jump=0, alu_op=001, with every other output 0.
- R6: Opcode 000010 (jump) gives jump=1 and every other output 0, including alu_op=000.
- R7: Every other opcode value drives all outputs to 0, so reg_we, mem_we, branch and jump are all 0.
- R8: The alu_op class code is 100 for the register-register class, 010 for OR, 000 for add and 001 for subtract. Jump and unlisted opcodes give 000.
- R9: reg_we is 1 for exactly the opcodes 000000, 001101 and 100011. mem_we is 1 only for 101011. The two are never 1 together.
- R10: An output that the decoded instruction does not use is driven to 0, not left undefined. This covers reg_dst and mem_to_reg for store, ext_sign for branch, and all ALU-related outputs for jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode field of the current instruction |
| reg_dst | output | 1 | 1 selects rd as write register, 0 selects rt |
| alu_b_imm | output | 1 | 1 feeds the extended immediate to ALU operand B |
| mem_to_reg | output | 1 | 1 writes data-memory output back, 0 writes ALU result |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch on ALU zero |
| jump | output | 1 | Unconditional jump |
| ext_sign | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends |
| alu_op | output | 3 | Class code for the local ALU function decoder |

## Verification
The pair of functions that must never coincide is the register-file write and the memory write. A store must raise only the memory write, and the load and register classes must raise only the register write. The bench drives all 64 opcode values, one per cycle, back to back, so that every transition between a writing class and a non-writing class takes place. In each cycle it judges the two enables together against the expected row, alongside the full control word.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;

    localparam int OPC_W    = 6;
    localparam int ALUOP_W  = 3;
    localparam int N_ROWS   = 6;
    localparam int CTRL_W   = 8 + ALUOP_W;

    // Class codes consumed by the ALU function decoder
    localparam logic [ALUOP_W-1:0] ALUC_ADD  = 3'b000;
    localparam logic [ALUOP_W-1:0] ALUC_SUB  = 3'b001;
    localparam logic [ALUOP_W-1:0] ALUC_OR   = 3'b010;
    localparam logic [ALUOP_W-1:0] ALUC_FUNC = 3'b100;

    typedef enum logic [OPC_W-1:0] {
        OPC_REG   = 6'b000000,
        OPC_JMP   = 6'b000010,
        OPC_BEQ   = 6'b000100,
        OPC_ORI   = 6'b001101,
        OPC_LOAD  = 6'b100011,
        OPC_STORE = 6'b101011
    } opcode_e;

    typedef struct packed {
        logic                wsel_rd;
        logic                bsrc_imm;
        logic                wb_mem;
        logic                rf_we;
        logic                dm_we;
        logic                br;
        logic                jmp;
        logic                sext;
        logic [ALUOP_W-1:0]  aclass;
    } ctrl_t;

    localparam ctrl_t CTRL_SAFE = '0;

    // Opcode matched by each product-term row
    function automatic logic [OPC_W-1:0] row_opcode(input int r);
        case (r)
            0:       row_opcode = OPC_REG;
            1:       row_opcode = OPC_ORI;
            2:       row_opcode = OPC_LOAD;
            3:       row_opcode = OPC_STORE;
            4:       row_opcode = OPC_BEQ;
            default: row_opcode = OPC_JMP;
        endcase
    endfunction

    // Control word each row contributes; unused points are 0
    function automatic ctrl_t row_word(input int r);
        ctrl_t w;
        w = CTRL_SAFE;
        case (r)
            0: begin
                w.wsel_rd = 1'b1;
                w.rf_we   = 1'b1;
                w.aclass  = ALUC_FUNC;
            end
            1: begin
                w.bsrc_imm = 1'b1;
                w.rf_we    = 1'b1;
                w.aclass   = ALUC_OR;
            end
            2: begin
                w.bsrc_imm = 1'b1;
                w.wb_mem   = 1'b1;
                w.rf_we    = 1'b1;
                w.sext     = 1'b1;
                w.aclass   = ALUC_ADD;
            end
            3: begin
                w.bsrc_imm = 1'b1;
                w.dm_we    = 1'b1;
                w.sext     = 1'b1;
                w.aclass   = ALUC_ADD;
            end
            4: begin
                w.br     = 1'b1;
                w.aclass = ALUC_SUB;
            end
            default: begin
                w.jmp = 1'b1;
            end
        endcase
        return w;
    endfunction

    // Column of the OR-plane: which rows drive output bit b
    function automatic logic [N_ROWS-1:0] column_mask(input int b);
        logic [N_ROWS-1:0] m;
        ctrl_t w;
        m = '0;
        for (int r = 0; r < N_ROWS; r++) begin
            w = row_word(r);
            m[r] = w[b];
        end
        return m;
    endfunction

endpackage

// File: rtl/sc_row_match.sv
module sc_row_match
    import sc_ctrl_pkg::*;
#(
    parameter int W    = OPC_W,
    parameter int ROWS = N_ROWS
) (
    input  logic [W-1:0]    opc,
    output logic [ROWS-1:0] hit
);
    // One full-width product term per supported opcode
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam logic [W-1:0] KEY = row_opcode(r);
        assign hit[r] = &(~(opc ^ KEY));
    end
endmodule

// File: rtl/sc_or_plane.sv
module sc_or_plane
    import sc_ctrl_pkg::*;
#(
    parameter int ROWS = N_ROWS,
    parameter int COLS = CTRL_W
) (
    input  logic [ROWS-1:0] hit,
    output logic [COLS-1:0] word
);
    for (genvar b = 0; b < COLS; b++) begin : g_col
        localparam logic [ROWS-1:0] MASK = column_mask(b);
        assign word[b] = |(hit & MASK);
    end
endmodule

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
    import sc_ctrl_pkg::*;
(
    input  logic [5:0] opcode,
    output logic       reg_dst,
    output logic       alu_b_imm,
    output logic       mem_to_reg,
    output logic       reg_we,
    output logic       mem_we,
    output logic       branch,
    output logic       jump,
    output logic       ext_sign,
    output logic [2:0] alu_op
);
    logic [N_ROWS-1:0] row_hit;
    logic [CTRL_W-1:0] plane_out;
    ctrl_t             ctl;

    sc_row_match #(.W(OPC_W), .ROWS(N_ROWS)) u_match (
        .opc (opcode),
        .hit (row_hit)
    );

    sc_or_plane #(.ROWS(N_ROWS), .COLS(CTRL_W)) u_plane (
        .hit  (row_hit),
        .word (plane_out)
    );

    assign ctl        = ctrl_t'(plane_out);
    assign reg_dst    = ctl.wsel_rd;
    assign alu_b_imm  = ctl.bsrc_imm;
    assign mem_to_reg = ctl.wb_mem;
    assign reg_we     = ctl.rf_we;
    assign mem_we     = ctl.dm_we;
    assign branch     = ctl.br;
    assign jump       = ctl.jmp;
    assign ext_sign   = ctl.sext;
    assign alu_op     = ctl.aclass;
endmodule

// File: rtl/sc_main_ctrl_chk.sv
module sc_main_ctrl_chk (
    input logic [5:0] opcode,
    input logic       reg_dst,
    input logic       alu_b_imm,
    input logic       mem_to_reg,
    input logic       reg_we,
    input logic       mem_we,
    input logic       branch,
    input logic       jump,
    input logic       ext_sign,
    input logic [2:0] alu_op
);
    logic listed;
    assign listed = (opcode == 6'b000000) || (opcode == 6'b001101) ||
                    (opcode == 6'b100011) || (opcode == 6'b101011) ||
                    (opcode == 6'b000100) || (opcode == 6'b000010);

    always_comb begin
        // R9
        writes_exclusive_chk: assert (!(reg_we && mem_we));
        // R5
        branch_quiet_chk: assert (!branch ||
            (!reg_we && !mem_we && !jump && !alu_b_imm && alu_op == 3'b001));
        // R6
        jump_quiet_chk: assert (!jump ||
            (!reg_we && !mem_we && !branch && !alu_b_imm && alu_op == 3'b000));
        // R3
        load_path_chk: assert (!mem_to_reg ||
            (reg_we && alu_b_imm && ext_sign && !reg_dst));
        // R1
        rd_select_chk: assert (!reg_dst || (reg_we && alu_op == 3'b100));
        // R7
        illegal_quiet_chk: assert (listed ||
            ({reg_dst, alu_b_imm, mem_to_reg, reg_we, mem_we,
              branch, jump, ext_sign, alu_op} == 11'd0));
    end
endmodule

bind sc_main_ctrl sc_main_ctrl_chk u_chk (
    .opcode     (opcode),
    .reg_dst    (reg_dst),
    .alu_b_imm  (alu_b_imm),
    .mem_to_reg (mem_to_reg),
    .reg_we     (reg_we),
    .mem_we     (mem_we),
    .branch     (branch),
    .jump       (jump),
    .ext_sign   (ext_sign),
    .alu_op     (alu_op)
);

// File: tb/sc_main_ctrl_test.sv
`timescale 1ns/1ps
module sc_main_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [5:0] opcode = 6'h3F;
    logic       reg_dst, alu_b_imm, mem_to_reg, reg_we, mem_we;
    logic       branch, jump, ext_sign;
    logic [2:0] alu_op;

    sc_main_ctrl uut (
        .opcode     (opcode),
        .reg_dst    (reg_dst),
        .alu_b_imm  (alu_b_imm),
        .mem_to_reg (mem_to_reg),
        .reg_we     (reg_we),
        .mem_we     (mem_we),
        .branch     (branch),
        .jump       (jump),
        .ext_sign   (ext_sign),
        .alu_op     (alu_op)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [5:0]  op;
        logic [10:0] want;
    } item_t;

    item_t q[$];

    // Expected word {dst,bimm,m2r,rwe,mwe,br,j,sext,aluop[2:0]}
    function automatic logic [10:0] model(input logic [5:0] op);
        case (op)
            6'b000000: model = 11'b1_0_0_1_0_0_0_0_100;
            6'b001101: model = 11'b0_1_0_1_0_0_0_0_010;
            6'b100011: model = 11'b0_1_1_1_0_0_0_1_000;
            6'b101011: model = 11'b0_1_0_0_1_0_0_1_000;
            6'b000100: model = 11'b0_0_0_0_0_1_0_0_001;
            6'b000010: model = 11'b0_0_0_0_0_0_1_0_000;
            default:   model = 11'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'b000000: req_of = "R1";
            6'b001101: req_of = "R2";
            6'b100011: req_of = "R3";
            6'b101011: req_of = "R4";
            6'b000100: req_of = "R5";
            6'b000010: req_of = "R6";
            default:   req_of = "R7";
        endcase
    endfunction

    task automatic judge(input string tag, input logic [10:0] got,
                         input logic [10:0] exp, input logic [5:0] op);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s opcode=%b actual=%b expected=%b", tag, op, got, exp);
        end
    endtask

    // Driver: apply opcode just after the edge, queue its expectation
    task automatic drive(input logic [5:0] op);
        item_t it;
        @(posedge clk);
        #1;
        opcode  = op;
        it.op   = op;
        it.want = model(op);
        q.push_back(it);
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            logic [10:0] got;
            it  = q.pop_front();
            got = {reg_dst, alu_b_imm, mem_to_reg, reg_we, mem_we,
                   branch, jump, ext_sign, alu_op};
            judge(req_of(it.op), got, it.want, it.op);
            // R8 class code field
            judge("R8", {8'd0, alu_op}, {8'd0, it.want[2:0]}, it.op);
            // R9 write enables judged together
            judge("R9", {9'd0, reg_we, mem_we}, {9'd0, it.want[7:6]}, it.op);
            // R10 unused points of store, branch and jump are 0
            if (it.op == 6'b101011)
                judge("R10", {9'd0, reg_dst, mem_to_reg}, 11'd0, it.op);
            if (it.op == 6'b000100)
                judge("R10", {10'd0, ext_sign}, 11'd0, it.op);
            if (it.op == 6'b000010)
                judge("R10", {7'd0, alu_b_imm, alu_op}, 11'd0, it.op);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: undefined opcode held, all outputs 0 (R7)
        judge("R7", {reg_dst, alu_b_imm, mem_to_reg, reg_we, mem_we,
                     branch, jump, ext_sign, alu_op}, 11'd0, opcode);
        rst = 1'b0;
        // Listed opcodes, then a full sweep, then class alternations
        drive(6'b000000);
        drive(6'b001101);
        drive(6'b100011);
        drive(6'b101011);
        drive(6'b000100);
        drive(6'b000010);
        for (int i = 0; i < 64; i++) drive(6'(i));
        for (int k = 0; k < 4; k++) begin
            drive(6'b101011);
            drive(6'b100011);
            drive(6'b101011);
            drive(6'b000000);
            drive(6'b101010);
            drive(6'b001100);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule